// File: doc/BRIEF.md
# Byte-Wide Host Register Window

This block lets an 8-bit host processor reach three 16-bit internal targets through a small window of five byte registers. Three of the registers hold a target address. The other two hold the low and high halves of a data word. The host loads the address bytes first. It then moves words by accessing the two data bytes. The high data byte is the trigger for a transfer in both directions. A write to it sends the assembled word to the selected target. A read of it fetches a word from the target, and the low half of that word stays available for a following read of the low data byte.

The two top bits of the high address byte choose the target. The targets are a coded-data FIFO (held inside the block, with a pop port facing the consumer), a word-addressed memory port, and an internal register bus. One of the two memory codes steps the stored 21-bit word address after every completed transfer, so the host can stream through memory without rewriting the address. Address bytes keep their values between accesses. The host side uses a four-phase request/acknowledge handshake. Each downstream target uses a request that is held until the target acknowledges it.

Top module: `hrw_top`

## Requirements
- R1: After reset, all five window registers read as 0x00, no host acknowledge is pending, no downstream request is active and the FIFO is empty.
- R2: Register select codes 1, 2 and 3 address the low, middle and high address bytes; 4 and 5 address the low and high data bytes. A written address byte reads back unchanged.
- R3: Select codes 0, 6 and 7 are illegal. A write with them changes no register, a read with them returns 0x00, and the access is still acknowledged.
- R4: With target code 2'b10 in bits [7:6] of the high address byte, a write of the high data byte issues one register-bus write with register number equal to bits [5:0] of that byte and data {high byte, low byte}.
- R5: A read of the high data byte with a register-bus or memory target fetches a 16-bit word and returns its upper byte. A following read of the low data byte returns the lower byte of the same word.
- R6: Memory targets (codes 2'b01 and 2'b11) use the word address {high[4:0], middle, low} and report bit 4 of the low address byte as the ROM/DRAM select (1 = ROM).
- R7: With code 2'b11, each completed memory transfer adds one to the 21-bit word address, with carry into high-byte bits [4:0], leaving bits [7:5] unchanged and wrapping to zero. With code 2'b01 the address bytes are unchanged.
- R8: With code 2'b00, each high-data-byte write pushes {high, low} into a 31-word FIFO, and words leave in the order they were written.
- R9: A FIFO write while the FIFO holds 31 words is not acknowledged until a pop frees a slot. The stalled word is then stored.
- R10: A high-data-byte read with FIFO target returns 0x00, loads 0x0000 into the data bytes, issues no downstream request and leaves the FIFO contents unchanged.
- R11: Only one downstream request or FIFO push is active at a time. A memory or register-bus request stays asserted, with a stable address, until acknowledged.
- R12: The host acknowledge is a one-cycle pulse. The next access is taken only after the host drops its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Window register select |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | One-cycle access acknowledge |
| host_rdata | output | 8 | Read byte, valid with host_ack |
| fifo_pop | input | 1 | Consumer removes the head word |
| fifo_dout | output | 16 | FIFO head word |
| fifo_empty | output | 1 | FIFO holds no word |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_rom | output | 1 | ROM (1) or DRAM (0) select |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | Memory transfer done |
| reg_req | output | 1 | Register-bus request |
| reg_we | output | 1 | Register-bus write (1) or read (0) |
| reg_num | output | REG_W | Internal register number |
| reg_wdata | output | 16 | Register-bus write word |
| reg_rdata | input | 16 | Register-bus read word, valid with reg_ack |
| reg_ack | input | 1 | Register-bus transfer done |

## Verification
A wrong address register does not show at once. It appears on mem_addr or reg_num at the next high-data-byte access, or on host_rdata at the next read-back of that byte. An auto-increment fault is therefore checked by reading all three address bytes back right after each memory transfer, including the carry and wrap points. A wrong FIFO count or pointer shows as a missing stall on the 32nd write, or as a word out of order on fifo_dout during the drain. A stuck controller state shows as a missing or stretched host_ack within a few cycles of the request.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;
   localparam int ADDR_FIELD_W = 21;   // {high[4:0], middle, low}

   // window register select codes
   localparam logic [2:0] SEL_ADR0 = 3'd1;
   localparam logic [2:0] SEL_ADR1 = 3'd2;
   localparam logic [2:0] SEL_ADR2 = 3'd3;
   localparam logic [2:0] SEL_DLO  = 3'd4;
   localparam logic [2:0] SEL_DHI  = 3'd5;

   // target code held in bits [7:6] of the high address byte
   typedef enum logic [1:0] {
      TGT_FIFO   = 2'b00,
      TGT_MEM    = 2'b01,
      TGT_REGBUS = 2'b10,
      TGT_MEMINC = 2'b11
   } tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XFER,
      ST_ACK,
      ST_HOLD
   } win_state_e;

endpackage

// File: rtl/hrw_fifo.sv
module hrw_fifo #(
   parameter int DEPTH = 31,
   parameter int W     = 16,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = store[rd_ptr];

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) store[wr_ptr] <= din;
   end

endmodule

// File: rtl/hrw_regs.sv
module hrw_regs
   import hrw_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    byte_we,
   input  logic [2:0]              byte_sel,
   input  logic [BYTE_W-1:0]       byte_wdata,
   input  logic [2:0]              rd_sel,
   output logic [BYTE_W-1:0]       rd_byte,
   input  logic                    word_ld,
   input  logic [WORD_W-1:0]       word_in,
   input  logic                    addr_inc,
   output logic [BYTE_W-1:0]       adr0,
   output logic [BYTE_W-1:0]       adr1,
   output logic [BYTE_W-1:0]       adr2,
   output logic [WORD_W-1:0]       data_word,
   output logic [ADDR_FIELD_W-1:0] addr_word
);

   logic [BYTE_W-1:0] dlo, dhi;

   assign data_word = {dhi, dlo};
   assign addr_word = {adr2[4:0], adr1, adr0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adr0 <= '0;
         adr1 <= '0;
         adr2 <= '0;
         dlo  <= '0;
         dhi  <= '0;
      end else begin
         if (byte_we) begin
            case (byte_sel)
               SEL_ADR0: adr0 <= byte_wdata;
               SEL_ADR1: adr1 <= byte_wdata;
               SEL_ADR2: adr2 <= byte_wdata;
               SEL_DLO:  dlo  <= byte_wdata;
               SEL_DHI:  dhi  <= byte_wdata;
               default:  ;
            endcase
         end
         if (word_ld) {dhi, dlo} <= word_in;
         if (addr_inc) {adr2[4:0], adr1, adr0} <= addr_word + 1'b1;
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_ADR0: rd_byte = adr0;
         SEL_ADR1: rd_byte = adr1;
         SEL_ADR2: rd_byte = adr2;
         SEL_DLO:  rd_byte = dlo;
         SEL_DHI:  rd_byte = dhi;
         default:  rd_byte = '0;
      endcase
   end

endmodule

// File: rtl/hrw_ctrl.sv
module hrw_ctrl
   import hrw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   output logic              host_ack,
   output logic [BYTE_W-1:0] host_rdata,
   input  logic [BYTE_W-1:0] rd_byte,
   input  tgt_e              tgt,
   input  logic              fifo_full,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              reg_ack,
   input  logic [WORD_W-1:0] reg_rdata,
   output logic              byte_we,
   output logic              word_ld,
   output logic [WORD_W-1:0] word_in,
   output logic              addr_inc,
   output logic              mem_req,
   output logic              reg_req,
   output logic              xfer_we,
   output logic              fifo_push
);

   win_state_e state;
   logic       legal, take, trig, xfer_done;

   assign legal = (host_sel >= SEL_ADR0) && (host_sel <= SEL_DHI);
   assign take  = (state == ST_IDLE) && host_req;
   assign trig  = take && (host_sel == SEL_DHI);

   assign mem_req   = (state == ST_XFER) && (tgt == TGT_MEM || tgt == TGT_MEMINC);
   assign reg_req   = (state == ST_XFER) && (tgt == TGT_REGBUS);
   assign fifo_push = (state == ST_XFER) && (tgt == TGT_FIFO) && xfer_we && !fifo_full;

   always_comb begin
      case (tgt)
         TGT_FIFO:   xfer_done = !fifo_full;
         TGT_REGBUS: xfer_done = reg_ack;
         default:    xfer_done = mem_ack;
      endcase
   end

   always_comb begin
      case (tgt)
         TGT_REGBUS: word_in = reg_rdata;
         TGT_FIFO:   word_in = '0;
         default:    word_in = mem_rdata;
      endcase
   end

   assign byte_we  = take && host_we && legal;
   assign word_ld  = (trig && !host_we && tgt == TGT_FIFO) ||
                     ((state == ST_XFER) && xfer_done && !xfer_we);
   assign addr_inc = (state == ST_XFER) && xfer_done && (tgt == TGT_MEMINC);
   assign host_ack = (state == ST_ACK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         xfer_we    <= 1'b0;
         host_rdata <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (trig && (host_we || tgt != TGT_FIFO)) begin
                  xfer_we <= host_we;
                  state   <= ST_XFER;
               end else if (take) begin
                  if (!host_we) host_rdata <= trig ? '0 : rd_byte;
                  state <= ST_ACK;
               end
            end
            ST_XFER: begin
               if (xfer_done) begin
                  if (!xfer_we) host_rdata <= word_in[WORD_W-1:BYTE_W];
                  state <= ST_ACK;
               end
            end
            ST_ACK:  state <= host_req ? ST_HOLD : ST_IDLE;
            default: if (!host_req) state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hrw_top.sv
module hrw_top
   import hrw_pkg::*;
#(
   parameter int FIFO_DEPTH = 31,
   parameter int MEM_AW     = 21,
   parameter int REG_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   input  logic [7:0]        host_wdata,
   output logic              host_ack,
   output logic [7:0]        host_rdata,
   input  logic              fifo_pop,
   output logic [15:0]       fifo_dout,
   output logic              fifo_empty,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_rom,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              reg_req,
   output logic              reg_we,
   output logic [REG_W-1:0]  reg_num,
   output logic [15:0]       reg_wdata,
   input  logic [15:0]       reg_rdata,
   input  logic              reg_ack
);

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("hrw_top: FIFO_DEPTH must be at least 2");
      end
      if (MEM_AW < 1 || MEM_AW > ADDR_FIELD_W) begin : g_bad_aw
         $error("hrw_top: MEM_AW must lie in 1..21");
      end
      if (REG_W < 1 || REG_W > 6) begin : g_bad_rw
         $error("hrw_top: REG_W must lie in 1..6");
      end
   endgenerate

   logic [BYTE_W-1:0]       adr0, adr1, adr2, rd_byte;
   logic [WORD_W-1:0]       data_word, word_in;
   logic [ADDR_FIELD_W-1:0] addr_word;
   logic                    byte_we, word_ld, addr_inc, xfer_we;
   logic                    fifo_push, fifo_full;
   logic [CNT_W-1:0]        fifo_count;
   tgt_e                    tgt;

   assign tgt = tgt_e'(adr2[7:6]);

   hrw_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_we    (byte_we),
      .byte_sel   (host_sel),
      .byte_wdata (host_wdata),
      .rd_sel     (host_sel),
      .rd_byte    (rd_byte),
      .word_ld    (word_ld),
      .word_in    (word_in),
      .addr_inc   (addr_inc),
      .adr0       (adr0),
      .adr1       (adr1),
      .adr2       (adr2),
      .data_word  (data_word),
      .addr_word  (addr_word)
   );

   hrw_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_req   (host_req),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_ack   (host_ack),
      .host_rdata (host_rdata),
      .rd_byte    (rd_byte),
      .tgt        (tgt),
      .fifo_full  (fifo_full),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .reg_ack    (reg_ack),
      .reg_rdata  (reg_rdata),
      .byte_we    (byte_we),
      .word_ld    (word_ld),
      .word_in    (word_in),
      .addr_inc   (addr_inc),
      .mem_req    (mem_req),
      .reg_req    (reg_req),
      .xfer_we    (xfer_we),
      .fifo_push  (fifo_push)
   );

   hrw_fifo #(
      .DEPTH (FIFO_DEPTH),
      .W     (WORD_W)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .din   (data_word),
      .pop   (fifo_pop),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .empty (fifo_empty),
      .count (fifo_count)
   );

   assign mem_we    = xfer_we;
   assign mem_rom   = adr0[4];
   assign mem_addr  = addr_word[MEM_AW-1:0];
   assign mem_wdata = data_word;
   assign reg_we    = xfer_we;
   assign reg_num   = adr2[REG_W-1:0];
   assign reg_wdata = data_word;

endmodule

// File: rtl/hrw_checks.sv
module hrw_checks #(
   parameter int FIFO_DEPTH = 31,
   parameter int MEM_AW     = 21,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_req,
   input logic              host_ack,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [MEM_AW-1:0] mem_addr,
   input logic              reg_req,
   input logic              reg_ack,
   input logic              fifo_push,
   input logic [CNT_W-1:0]  fifo_count,
   input logic              addr_inc,
   input logic [20:0]       addr_word
);

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);   // R12

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ack) |-> $past(host_req));   // R12

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, reg_req, fifo_push}));   // R11

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));   // R11

   AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=> reg_req);   // R11

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == CNT_W'(FIFO_DEPTH)) |-> !fifo_push);   // R9

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      addr_inc |=> (addr_word == $past(addr_word) + 21'd1));   // R7

endmodule

bind hrw_top hrw_checks #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .MEM_AW     (MEM_AW)
) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_req   (host_req),
   .host_ack   (host_ack),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .reg_req    (reg_req),
   .reg_ack    (reg_ack),
   .fifo_push  (fifo_push),
   .fifo_count (fifo_count),
   .addr_inc   (addr_inc),
   .addr_word  (addr_word)
);

// File: tb/hrw_top_test.sv
module hrw_top_test;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [2:0]  host_sel = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_ack;
   logic [7:0]  host_rdata;
   logic        fifo_pop = 1'b0;
   logic [15:0] fifo_dout;
   logic        fifo_empty;
   logic        mem_req, mem_we, mem_rom;
   logic [20:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;
   logic        mem_ack = 1'b0;
   logic        reg_req, reg_we;
   logic [5:0]  reg_num;
   logic [15:0] reg_wdata, reg_rdata;
   logic        reg_ack = 1'b0;

   int checks = 0, fails = 0, pulse_err = 0;
   int mem_cnt = 0, reg_cnt = 0;
   logic [1:0]  mem_dly = '0, reg_dly = '0;
   logic [20:0] last_mem_addr;
   logic [15:0] last_mem_wdata, last_reg_wdata;
   logic        last_mem_we, last_mem_rom, last_reg_we;
   logic [5:0]  last_reg_num;
   logic [7:0]  rd;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hrw_top uut (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
      .fifo_pop(fifo_pop), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
      .mem_req(mem_req), .mem_we(mem_we), .mem_rom(mem_rom), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .reg_req(reg_req), .reg_we(reg_we), .reg_num(reg_num),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack)
   );

   // downstream models: read data is a fixed function of the address
   assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;
   assign reg_rdata = {reg_num, 2'b01, ~reg_num, 2'b10};

   function automatic logic [15:0] reg_word(input logic [5:0] n);
      return {n, 2'b01, ~n, 2'b10};
   endfunction

   function automatic logic [15:0] fword(input int k);
      return 16'h1000 + 16'(k) * 16'h0111;
   endfunction

   always @(negedge clk) begin
      if (!mem_req || mem_ack) begin mem_dly <= '0; mem_ack <= 1'b0; end
      else if (mem_dly == 2'd1) mem_ack <= 1'b1;
      else mem_dly <= mem_dly + 1'b1;
      if (!reg_req || reg_ack) begin reg_dly <= '0; reg_ack <= 1'b0; end
      else if (reg_dly == 2'd1) reg_ack <= 1'b1;
      else reg_dly <= reg_dly + 1'b1;
   end

   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         mem_cnt++;
         last_mem_addr  <= mem_addr;
         last_mem_we    <= mem_we;
         last_mem_rom   <= mem_rom;
         last_mem_wdata <= mem_wdata;
      end
      if (reg_req && reg_ack) begin
         reg_cnt++;
         last_reg_num   <= reg_num;
         last_reg_we    <= reg_we;
         last_reg_wdata <= reg_wdata;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [2:0] sel, input logic [7:0] wd,
                         output logic [7:0] rdv);
      int n;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = wd;
      n = 0;
      do begin @(negedge clk); n++; end while (!host_ack && n < 60);
      rdv = host_rdata;
      host_req = 1'b0;
      @(negedge clk);
      if (host_ack) pulse_err++;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] wd);
      logic [7:0] dummy;
      access(1'b1, sel, wd, dummy);
   endtask

   task automatic rdb(input logic [2:0] sel, output logic [7:0] v);
      access(1'b0, sel, 8'h00, v);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      int m0, r0;
      logic [7:0] ah, al;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 ack", host_ack, 0);
      chk("R1 req", {mem_req, reg_req}, 0);
      chk("R1 empty", fifo_empty, 1);
      for (int s = 1; s <= 5; s++) begin
         rdb(3'(s), rd);
         chk("R1 reg zero", rd, 0);
      end

      // R2: address bytes read back
      for (int v = 0; v < 4; v++) begin
         for (int s = 1; s <= 3; s++) wr(3'(s), 8'(s * 8'h35) ^ 8'(v * 8'h4B));
         for (int s = 1; s <= 3; s++) begin
            rdb(3'(s), rd);
            chk("R2 readback", rd, 8'(s * 8'h35) ^ 8'(v * 8'h4B));
         end
      end

      // R3: illegal select codes
      wr(3'd1, 8'h11); wr(3'd2, 8'h22); wr(3'd3, 8'h33); wr(3'd4, 8'h44);
      for (int i = 0; i < 3; i++) begin
         logic [2:0] bad;
         bad = (i == 0) ? 3'd0 : 3'(5 + i);
         wr(bad, 8'hFF);
         rdb(bad, rd);
         chk("R3 illegal read", rd, 0);
      end
      rdb(3'd1, rd); chk("R3 adr0 kept", rd, 8'h11);
      rdb(3'd2, rd); chk("R3 adr1 kept", rd, 8'h22);
      rdb(3'd3, rd); chk("R3 adr2 kept", rd, 8'h33);
      rdb(3'd4, rd); chk("R3 dlo kept", rd, 8'h44);

      // R4 / R5: register bus
      for (int i = 0; i < 5; i++) begin
         logic [5:0] n;
         n = (i == 0) ? 6'h00 : (i == 1) ? 6'h01 : (i == 2) ? 6'h15 : (i == 3) ? 6'h2A : 6'h3F;
         wr(3'd3, {2'b10, n});
         r0 = reg_cnt;
         wr(3'd4, {2'b00, n} ^ 8'h5A);
         wr(3'd5, {2'b00, n} + 8'h01);
         chk("R4 one write", reg_cnt - r0, 1);
         chk("R4 num", last_reg_num, n);
         chk("R4 we", last_reg_we, 1);
         chk("R4 data", last_reg_wdata, {{2'b00, n} + 8'h01, {2'b00, n} ^ 8'h5A});
         rdb(3'd5, rd);
         chk("R5 reg high", rd, reg_word(n) >> 8);
         rdb(3'd4, rd);
         chk("R5 reg low", rd, reg_word(n) & 16'hFF);
         chk("R5 read cycle", last_reg_we, 0);
      end

      // R6: plain memory target
      wr(3'd1, 8'h10); wr(3'd2, 8'h34); wr(3'd3, 8'h45);
      wr(3'd4, 8'h77); wr(3'd5, 8'h88);
      chk("R6 addr", last_mem_addr, 21'h053410);
      chk("R6 rom", last_mem_rom, 1);
      chk("R6 we", last_mem_we, 1);
      chk("R6 wdata", last_mem_wdata, 16'h8877);
      rdb(3'd1, rd); chk("R7 no step adr0", rd, 8'h10);
      wr(3'd1, 8'h0F);
      rdb(3'd5, ah); rdb(3'd4, al);
      chk("R6 read addr", last_mem_addr, 21'h05340F);
      chk("R6 dram", last_mem_rom, 0);
      chk("R5 mem word", {ah, al}, 16'h340F ^ 16'h5A3C);
      rdb(3'd1, rd); chk("R7 no step after read", rd, 8'h0F);

      // R7: auto-increment with carry and wrap
      wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hE3);
      wr(3'd5, 8'h01);
      chk("R7 write addr", last_mem_addr, 21'h03FFFF);
      rdb(3'd1, rd); chk("R7 carry adr0", rd, 8'h00);
      rdb(3'd2, rd); chk("R7 carry adr1", rd, 8'h00);
      rdb(3'd3, rd); chk("R7 carry adr2", rd, 8'hE4);
      rdb(3'd5, ah); rdb(3'd4, al);
      chk("R7 read addr", last_mem_addr, 21'h040000);
      chk("R7 read word", {ah, al}, 16'h5A3C);
      rdb(3'd1, rd); chk("R7 step after read", rd, 8'h01);
      wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
      wr(3'd5, 8'h02);
      rdb(3'd1, rd); chk("R7 wrap adr0", rd, 8'h00);
      rdb(3'd2, rd); chk("R7 wrap adr1", rd, 8'h00);
      rdb(3'd3, rd); chk("R7 wrap adr2", rd, 8'hE0);

      // R10: FIFO target read while empty
      wr(3'd3, 8'h00);
      m0 = mem_cnt; r0 = reg_cnt;
      rdb(3'd5, rd); chk("R10 high zero", rd, 0);
      rdb(3'd4, rd); chk("R10 low zero", rd, 0);
      chk("R10 no request", (mem_cnt - m0) + (reg_cnt - r0), 0);
      chk("R10 fifo untouched", fifo_empty, 1);

      // R8: fill the FIFO
      for (int k = 0; k < DEPTH; k++) begin
         wr(3'd4, fword(k) & 16'hFF);
         wr(3'd5, fword(k) >> 8);
      end
      chk("R8 not empty", fifo_empty, 0);
      chk("R8 head", fifo_dout, fword(0));
      rdb(3'd5, rd); chk("R10 read when full", rd, 0);
      chk("R10 head kept", fifo_dout, fword(0));

      // R9: stall on a full FIFO
      wr(3'd4, fword(DEPTH) & 16'hFF);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_sel = 3'd5; host_wdata = fword(DEPTH) >> 8;
      begin
         int seen;
         seen = 0;
         repeat (6) begin @(negedge clk); if (host_ack) seen++; end
         chk("R9 stalled while full", seen, 0);
         fifo_pop = 1'b1;
         @(negedge clk);
         fifo_pop = 1'b0;
         seen = 0;
         for (int t = 0; t < 6 && seen == 0; t++) begin
            if (host_ack) seen = 1; else @(negedge clk);
         end
         chk("R9 released after pop", seen, 1);
         host_req = 1'b0;
         @(negedge clk);
         if (host_ack) pulse_err++;
      end

      // R8: drain in order, stalled word last
      for (int k = 1; k <= DEPTH; k++) begin
         chk("R8 order", fifo_dout, fword(k));
         fifo_pop = 1'b1;
         @(negedge clk);
      end
      fifo_pop = 1'b0;
      chk("R8 drained", fifo_empty, 1);

      // R12: every acknowledge was a single pulse
      chk("R12 ack pulse", pulse_err, 0);

      summary();
   end

endmodule